// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits after an external dual-modulus prescaler in a frequency synthesizer loop. It runs on the prescaler's output, so one clock of the block is one prescaler output period. Over each division cycle it counts N prescaler periods with a main counter. During the first A of those periods a swallow counter holds the modulus-control output high, which asks the prescaler to divide by P+1. For the remaining N−A periods the output is low and the prescaler divides by P. Seen from the oscillator, the total ratio is A·(P+1) + (N−A)·P = P·N + A. The block never needs to know P.

New ratios arrive as an N/A pair with a load strobe. A pair that passes the range checks (N at least 3, A strictly below N) waits in a staging register. It is applied only at the next cycle boundary, so a cycle already in progress is never cut short or stretched. A pair that fails the checks is dropped, the ratio in use stays as it was, and an error flag goes high. A single-clock divided output pulse marks the last prescaler period of every cycle.

Top module: `swallow_divider`

## Requirements
- R1: Every division cycle lasts exactly N clocks of `clk`. `divOut` is high for exactly one clock per cycle, the last clock of that cycle.
- R2: `modCtl` (1 = prescaler divides by P+1, 0 = divides by P) is high for the first A clocks of a cycle and low for the other N−A. The weighted sum over a cycle is therefore P·N + A oscillator periods.
- R3: When A = 0, `modCtl` stays low for the whole cycle.
- R4: A valid pair taken on `progLoad` does not alter the cycle in progress. It governs every cycle that starts after the next `divOut` clock.
- R5: A pair taken on `progLoad` with `progN` < 3 or `progA` ≥ `progN` is discarded, so the ratio in use keeps its previous values. `cfgErr` reads 1 from the clock after the load.
- R6: A valid load sets `cfgErr` to 0 from the next clock. Without `progLoad`, `cfgErr` keeps its value.
- R7: After reset, `cfgErr` is 0 and the first cycle uses the reset ratio (`RESET_N_VAL`, `RESET_A_VAL`). That first cycle lasts `RESET_N_VAL` clocks, with `modCtl` high on its first `RESET_A_VAL` clocks.
- R8: `modCtl` only rises on the first clock of a cycle, that is, one clock after `divOut`. It is low whenever `divOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, one rising edge per prescaler period |
| rstN | input | 1 | Asynchronous reset, active low |
| progN | input | N_WIDTH | Requested main-counter ratio N |
| progA | input | A_WIDTH | Requested swallow count A |
| progLoad | input | 1 | One-clock strobe that offers progN/progA |
| modCtl | output | 1 | Modulus select to the prescaler, 1 = divide by P+1 |
| divOut | output | 1 | Divided output, one clock per division cycle |
| cfgErr | output | 1 | Last offered pair was rejected |

## Verification
The bench builds the block with a 5-bit N and a 4-bit A and a reset ratio of N = 5, A = 2. At that width every legal pair (N from 3 to 31, A from 0 to min(N−1, 15)) can be loaded in turn. For each pair the bench measures the cycle length, the number of high `modCtl` clocks and the weighted oscillator count for P = 16. Both edges of the legal space are covered: A = 0, A = N−1 and the largest values. The smaller width also keeps loads in the middle of a cycle and the rejection of pairs at the range limits cheap enough to check at the ports.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;

  // Strobes issued by the control to the counter datapath each clock
  typedef struct packed {
    logic reload;       // last clock of a cycle: load both counters
    logic stepSwallow;  // swallow counter still nonzero: decrement it
  } dpStrobe_t;

endpackage

// File: rtl/swallow_divider_ctrl.sv
module swallow_divider_ctrl
  import swallow_divider_pkg::*;
#(
  parameter int N_WIDTH     = 11,
  parameter int A_WIDTH     = 7,
  parameter int N_MIN       = 3,
  parameter int RESET_N_VAL = 16,
  parameter int RESET_A_VAL = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_WIDTH-1:0] progN,
  input  logic [A_WIDTH-1:0] progA,
  input  logic               progLoad,
  input  logic               mainLast,
  input  logic               swZero,
  output dpStrobe_t          strobe,
  output logic [N_WIDTH-1:0] reloadN,
  output logic [A_WIDTH-1:0] reloadA,
  output logic               cfgErr
);

  localparam int PAD = N_WIDTH - A_WIDTH;
  localparam logic [N_WIDTH-1:0] RST_N = N_WIDTH'(RESET_N_VAL);
  localparam logic [A_WIDTH-1:0] RST_A = A_WIDTH'(RESET_A_VAL);
  localparam logic [N_WIDTH-1:0] LIM_N = N_WIDTH'(N_MIN);

  logic [N_WIDTH-1:0] actN, pendN;
  logic [A_WIDTH-1:0] actA, pendA;
  logic               pendValid;
  logic [N_WIDTH-1:0] aWide;
  logic               pairOk, loadOk, takePending;

  // Range checks on the offered pair
  assign aWide       = {{PAD{1'b0}}, progA};
  assign pairOk      = (progN >= LIM_N) && (aWide < progN);
  assign loadOk      = progLoad && pairOk;
  assign takePending = mainLast && pendValid;

  // Staged values win at a boundary; otherwise repeat the active ratio
  assign reloadN = takePending ? pendN : actN;
  assign reloadA = takePending ? pendA : actA;

  always_comb begin
    strobe.reload      = mainLast;
    strobe.stepSwallow = !swZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actN      <= RST_N;
      actA      <= RST_A;
      pendN     <= '0;
      pendA     <= '0;
      pendValid <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (takePending) begin
        actN <= pendN;
        actA <= pendA;
      end
      if (loadOk) begin
        pendN <= progN;
        pendA <= progA;
      end
      pendValid <= loadOk || (pendValid && !takePending);
      if (progLoad) cfgErr <= !pairOk;
    end
  end

endmodule

// File: rtl/swallow_divider_dp.sv
module swallow_divider_dp
  import swallow_divider_pkg::*;
#(
  parameter int N_WIDTH     = 11,
  parameter int A_WIDTH     = 7,
  parameter int RESET_N_VAL = 16,
  parameter int RESET_A_VAL = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [N_WIDTH-1:0] reloadN,
  input  logic [A_WIDTH-1:0] reloadA,
  output logic               mainLast,
  output logic               swZero
);

  localparam logic [N_WIDTH-1:0] RST_N = N_WIDTH'(RESET_N_VAL);
  localparam logic [A_WIDTH-1:0] RST_A = A_WIDTH'(RESET_A_VAL);
  localparam logic [N_WIDTH-1:0] ONE_N = N_WIDTH'(1);

  logic [N_WIDTH-1:0] mainCnt;
  logic [A_WIDTH-1:0] swCnt;

  assign mainLast = (mainCnt == ONE_N);
  assign swZero   = (swCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= RST_N;
      swCnt   <= RST_A;
    end else if (strobe.reload) begin
      mainCnt <= reloadN;
      swCnt   <= reloadA;
    end else begin
      mainCnt <= mainCnt - ONE_N;
      if (strobe.stepSwallow) swCnt <= swCnt - A_WIDTH'(1);
    end
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_divider_pkg::*;
#(
  parameter int N_WIDTH     = 11,
  parameter int A_WIDTH     = 7,
  parameter int N_MIN       = 3,
  parameter int RESET_N_VAL = 16,
  parameter int RESET_A_VAL = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_WIDTH-1:0] progN,
  input  logic [A_WIDTH-1:0] progA,
  input  logic               progLoad,
  output logic               modCtl,
  output logic               divOut,
  output logic               cfgErr
);

  dpStrobe_t          strobe;
  logic [N_WIDTH-1:0] reloadN;
  logic [A_WIDTH-1:0] reloadA;
  logic               mainLast, swZero;

  swallow_divider_ctrl #(
    .N_WIDTH(N_WIDTH), .A_WIDTH(A_WIDTH), .N_MIN(N_MIN),
    .RESET_N_VAL(RESET_N_VAL), .RESET_A_VAL(RESET_A_VAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .progN(progN), .progA(progA),
    .progLoad(progLoad), .mainLast(mainLast), .swZero(swZero),
    .strobe(strobe), .reloadN(reloadN), .reloadA(reloadA),
    .cfgErr(cfgErr)
  );

  swallow_divider_dp #(
    .N_WIDTH(N_WIDTH), .A_WIDTH(A_WIDTH),
    .RESET_N_VAL(RESET_N_VAL), .RESET_A_VAL(RESET_A_VAL)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reloadN(reloadN), .reloadA(reloadA),
    .mainLast(mainLast), .swZero(swZero)
  );

  assign modCtl = !swZero;
  assign divOut = mainLast;

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int N_WIDTH = 11,
  parameter int A_WIDTH = 7,
  parameter int N_MIN   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [N_WIDTH-1:0] progN,
  input logic [A_WIDTH-1:0] progA,
  input logic               progLoad,
  input logic               modCtl,
  input logic               divOut,
  input logic               cfgErr
);

  logic badPair;
  assign badPair = (progN < N_WIDTH'(N_MIN)) ||
                   ({{(N_WIDTH-A_WIDTH){1'b0}}, progA} >= progN);

  AST_BAD_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    progLoad && badPair |=> cfgErr); // R5

  AST_GOOD_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    progLoad && !badPair |=> !cfgErr); // R6

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !progLoad |=> $stable(cfgErr)); // R6

  AST_MOD_LOW_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    divOut |-> !modCtl); // R8

  AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> $past(divOut)); // R8

endmodule

bind swallow_divider swallow_divider_chk #(
  .N_WIDTH(N_WIDTH), .A_WIDTH(A_WIDTH), .N_MIN(N_MIN)
) uChk (
  .clk(clk), .rstN(rstN), .progN(progN), .progA(progA),
  .progLoad(progLoad), .modCtl(modCtl), .divOut(divOut), .cfgErr(cfgErr)
);

// File: tb/tb_swallow_divider.sv
`timescale 1ns/1ps
module tb_swallow_divider;

  localparam int NW    = 5;
  localparam int AW    = 4;
  localparam int PRESC = 16;
  localparam int RN    = 5;
  localparam int RA    = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW-1:0] progN = '0;
  logic [AW-1:0] progA = '0;
  logic          progLoad = 1'b0;
  logic          modCtl, divOut, cfgErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  swallow_divider #(
    .N_WIDTH(NW), .A_WIDTH(AW), .N_MIN(3),
    .RESET_N_VAL(RN), .RESET_A_VAL(RA)
  ) dut (
    .clk(clk), .rstN(rstN), .progN(progN), .progA(progA),
    .progLoad(progLoad), .modCtl(modCtl), .divOut(divOut), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a pair on a falling edge, hold it for one rising edge
  task automatic loadPair(input int n, input int a);
    progN    = NW'(n);
    progA    = AW'(a);
    progLoad = 1'b1;
    @(negedge clk);
    progLoad = 1'b0;
  endtask

  task automatic syncBoundary();
    while (!divOut) @(negedge clk);
  endtask

  // Entered on the falling edge that shows divOut; measures the next cycle
  task automatic measure(output int clocks, output int highs, output int vco);
    clocks = 0; highs = 0; vco = 0;
    do begin
      @(negedge clk);
      clocks++;
      if (modCtl) highs++;
      vco += modCtl ? PRESC + 1 : PRESC;
    end while (!divOut && clocks < 200);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 clocks", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int clocks, highs, vco, aMax;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7: reset state and first cycle using the reset ratio
    check("R7 cfgErr after reset", int'(cfgErr), 0);
    check("R7 modCtl first clock", int'(modCtl), 1);
    clocks = 1; highs = modCtl ? 1 : 0;
    while (!divOut) begin
      @(negedge clk);
      clocks++;
      if (modCtl) highs++;
    end
    check("R7 first cycle length", clocks, RN);
    check("R7 first cycle swallow", highs, RA);

    // R1 R2 R3: sweep every legal pair
    for (int n = 3; n < (1 << NW); n++) begin
      aMax = (n - 1 < (1 << AW) - 1) ? n - 1 : (1 << AW) - 1;
      for (int a = 0; a <= aMax; a++) begin
        loadPair(n, a);
        syncBoundary();
        measure(clocks, highs, vco);
        check("R1 cycle length", clocks, n);
        if (a == 0) check("R3 modCtl low when A=0", highs, 0);
        else        check("R2 modCtl high clocks", highs, a);
        check("R2 weighted ratio", vco, PRESC * n + a);
        check("R6 cfgErr after valid load", int'(cfgErr), 0);
      end
    end

    // R5: A equal to N is rejected, ratio 31/15 kept
    loadPair(5, 5);
    check("R5 flag for A>=N", int'(cfgErr), 1);
    syncBoundary();
    measure(clocks, highs, vco);
    check("R5 ratio kept after A>=N", clocks, 31);
    check("R5 swallow kept after A>=N", highs, 15);
    // R5: N below 3 is rejected
    loadPair(2, 0);
    check("R5 flag for N<3", int'(cfgErr), 1);
    syncBoundary();
    measure(clocks, highs, vco);
    check("R5 ratio kept after N<3", clocks, 31);
    check("R6 flag holds without load", int'(cfgErr), 1);
    // R6: valid load clears the flag
    loadPair(10, 0);
    check("R6 flag cleared", int'(cfgErr), 0);
    syncBoundary();
    measure(clocks, highs, vco);
    check("R3 A=0 cycle length", clocks, 10);
    check("R3 A=0 no swallow", highs, 0);

    // R4: load in the middle of a cycle
    @(negedge clk);          // clock 1 of a 10-clock cycle
    loadPair(7, 3);          // returns on clock 2
    clocks = 2;
    while (!divOut) begin
      @(negedge clk);
      clocks++;
    end
    check("R4 current cycle unchanged", clocks, 10);
    measure(clocks, highs, vco);
    check("R4 next cycle length", clocks, 7);
    check("R4 next cycle swallow", highs, 3);
    // R8: modCtl high on the first clock of a cycle with A>0
    @(negedge clk);
    check("R8 modCtl at cycle start", int'(modCtl), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule